// File: doc/BRIEF.md
# Cache Request Issuer with Retry Replay

This block sits between a pipeline and a cache port and handles one memory access at a time: an instruction fetch, a data load or a data store. Each access is presented to the port. When the port refuses it, the block keeps the access, marks itself blocked and waits for the port's retry pulse. It then presents the same access again in that same cycle. Once the port accepts, the block waits for the response and then reports completion with a one-cycle strobe and a result word.

Atomic pairs are handled locally. A load-linked access arms a single address reservation when its response returns. A store-conditional whose address does not match a live reservation never reaches the port. It completes at once with result 0. A store-conditional that does match is sent. Its completion returns 1 and clears the reservation. A plain store that completes to the reserved address also clears it. Load and fetch results are cut to the access width and zero-extended. A data access with an unsupported width is reported as an error without touching the port.

Top module: `mreq_issuer`

## Requirements
- R1: A request taken while `req_ready` is high (kind 00 fetch, 01 load, 10 store) drives `port_valid` in the next cycle with the request address and `port_write` high only for kind 10. `port_size` is 4 bytes for a fetch and `req_size` for a load or store.
- R2: If the port refuses (`port_valid` high, `port_accept` low), `blocked` rises in the next cycle. `port_valid` then stays low until a retry arrives, and the held address and size do not change.
- R3: A `port_retry` pulse while blocked drives the held request on the port in that same cycle. If the port accepts, `blocked` falls in the next cycle. If it refuses, `blocked` stays high.
- R4: While an access is in flight (any state other than idle, including blocked), `req_ready` is low and `req_valid` has no effect.
- R5: A `port_retry` pulse when the block is not waiting for a retry raises `retry_err` for exactly the next cycle.
- R6: `resp_valid` while waiting for the response raises `done` for one cycle and returns the block to idle. `resp_valid` at any other time is ignored.
- R7: A load or fetch result in `done_data` is the low 1, 2, 4 or 8 bytes of `resp_data`, chosen by the access size, with all higher bits zero. A plain store returns 0.
- R8: A load or store with `req_size` other than 1, 2, 4 or 8, or a request of kind 11, completes in the next cycle with `done` and `done_err` high and `done_data` 0, and the port is never driven.
- R9: The completion of a load with `req_atomic` high (load-linked) arms the reservation for its address.
- R10: A store with `req_atomic` high (store-conditional) whose address does not match an armed reservation completes in the next cycle with result 0 and no port access. A non-matching reservation stays armed.
- R11: A store-conditional that matches is sent to the port and completes with result 1, which disarms the reservation. A completed plain store to the reserved address also disarms it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request offered |
| req_kind | input | 2 | 00 fetch, 01 load, 10 store, 11 invalid |
| req_atomic | input | 1 | Load-linked on a load, store-conditional on a store |
| req_addr | input | ADDR_W | Access address |
| req_size | input | SIZE_W | Access width in bytes (ignored for fetch) |
| req_wdata | input | DATA_W | Store data |
| req_ready | output | 1 | Block idle, request taken |
| port_valid | output | 1 | Access presented to the cache port |
| port_write | output | 1 | Presented access is a store |
| port_addr | output | ADDR_W | Presented address |
| port_size | output | SIZE_W | Presented width in bytes |
| port_wdata | output | DATA_W | Presented store data |
| port_accept | input | 1 | Port takes the presented access this cycle |
| port_retry | input | 1 | Port invites a refused access again |
| resp_valid | input | 1 | Response for the outstanding access |
| resp_data | input | DATA_W | Response data |
| blocked | output | 1 | Waiting for a retry after a refusal |
| done | output | 1 | One-cycle completion strobe |
| done_data | output | DATA_W | Completion result |
| done_err | output | 1 | Completion is a size or kind error |
| retry_err | output | 1 | Retry pulse arrived when none was awaited |

## Verification
The assertions assume that `port_accept` carries meaning only in a cycle where `port_valid` is high. They also assume that the cache answers with at most one `resp_valid` per accepted access and only after accepting it. They do not assume that retries are well placed, because a misplaced retry is a case the block itself reports. The stimulus raises `port_accept` only in cycles where the bench expects the port to be driven, and sends exactly one response per accepted access. Stray retries and stray responses are injected only while the block is idle, to check that they are reported or ignored.

// File: rtl/mreq_pkg.sv
// Shared types for the cache request issuer.
// Assumes: kinds and states are encoded in two bits each.
package mreq_pkg;
    typedef enum logic [1:0] {
        K_FETCH = 2'b00,
        K_LOAD  = 2'b01,
        K_STORE = 2'b10,
        K_BAD   = 2'b11
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT_RETRY,
        ST_WAIT_RESP
    } state_e;
endpackage

// File: rtl/mreq_extract.sv
// Byte-lane result trimmer: keeps the low NBYTES bytes of a response word
// and zeroes the rest.
// Assumes: nbytes has already been checked to be 1, 2, 4 or 8 by the caller.
module mreq_extract #(
    parameter int DATA_W = 64,
    parameter int SIZE_W = 4
) (
    input  logic [DATA_W-1:0] raw,
    input  logic [SIZE_W-1:0] nbytes,
    output logic [DATA_W-1:0] value
);
    localparam int LANES = DATA_W / 8;

    // One mux per byte lane: the lane survives when its index is below nbytes.
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        localparam logic [SIZE_W:0] LANE_IDX = (SIZE_W+1)'(i);
        assign value[i*8 +: 8] = ({1'b0, nbytes} > LANE_IDX) ? raw[i*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/mreq_resv.sv
// Single-entry address reservation for load-linked / store-conditional pairs.
// Assumes: set and clear never coincide (only one access completes per cycle).
module mreq_resv #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              disarm,
    input  logic [ADDR_W-1:0] arm_addr,
    input  logic [ADDR_W-1:0] probe_addr,
    output logic              hit
);
    logic              live_q;
    logic [ADDR_W-1:0] addr_q;

    // Track whether a reservation is armed and for which address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_q <= 1'b0;
            addr_q <= '0;
        end else if (arm) begin
            live_q <= 1'b1;
            addr_q <= arm_addr;
        end else if (disarm) begin
            live_q <= 1'b0;
        end
    end

    // Report a match between the probe and the armed address.
    assign hit = live_q && (addr_q == probe_addr);
endmodule

// File: rtl/mreq_issuer.sv
// Cache request issuer: presents one access at a time to a cache port,
// replays a refused access on a retry pulse, waits for the response and
// completes failed store-conditionals and malformed requests locally.
// Assumes: the port answers at most once per accepted access, and
// port_accept is only meaningful while port_valid is high.
module mreq_issuer
    import mreq_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 64,
    parameter int SIZE_W     = 4,
    parameter int INSN_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic              req_atomic,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              req_ready,
    output logic              port_valid,
    output logic              port_write,
    output logic [ADDR_W-1:0] port_addr,
    output logic [SIZE_W-1:0] port_size,
    output logic [DATA_W-1:0] port_wdata,
    input  logic              port_accept,
    input  logic              port_retry,
    input  logic              resp_valid,
    input  logic [DATA_W-1:0] resp_data,
    output logic              blocked,
    output logic              done,
    output logic [DATA_W-1:0] done_data,
    output logic              done_err,
    output logic              retry_err
);
    localparam logic [SIZE_W-1:0] FETCH_SIZE = SIZE_W'(INSN_BYTES);

    state_e            state_q;
    kind_e             h_kind_q;
    logic              h_atomic_q;
    logic [ADDR_W-1:0] h_addr_q;
    logic [SIZE_W-1:0] h_size_q;
    logic [DATA_W-1:0] h_wdata_q;
    logic              blocked_q;
    logic              done_q;
    logic              done_err_q;
    logic              retry_err_q;
    logic [DATA_W-1:0] done_data_q;

    kind_e             in_kind;
    logic [SIZE_W-1:0] in_size;
    logic              take, reject, sc_fail, local_done;
    logic              retry_fire, sent, refused, finish;
    logic              resv_hit;
    logic [ADDR_W-1:0] probe_addr;
    logic [DATA_W-1:0] trimmed;
    logic [DATA_W-1:0] result;

    // Decode the incoming request: kind, effective width and local outcomes.
    always_comb begin
        in_kind    = kind_e'(req_kind);
        in_size    = (in_kind == K_FETCH) ? FETCH_SIZE : req_size;
        take       = req_valid && (state_q == ST_IDLE);
        reject     = (in_kind == K_BAD) ||
                     !(in_size == SIZE_W'(1) || in_size == SIZE_W'(2) ||
                       in_size == SIZE_W'(4) || in_size == SIZE_W'(8));
        sc_fail    = (in_kind == K_STORE) && req_atomic && !resv_hit;
        local_done = take && (reject || sc_fail);
    end

    // Port-side handshake terms.
    always_comb begin
        retry_fire = (state_q == ST_WAIT_RETRY) && port_retry;
        port_valid = (state_q == ST_ISSUE) || retry_fire;
        sent       = port_valid && port_accept;
        refused    = port_valid && !port_accept;
        finish     = (state_q == ST_WAIT_RESP) && resp_valid;
    end

    // Reservation probe address: the new request while idle, else the held one.
    assign probe_addr = (state_q == ST_IDLE) ? req_addr : h_addr_q;

    mreq_resv #(.ADDR_W(ADDR_W)) resv_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .arm        (finish && (h_kind_q == K_LOAD) && h_atomic_q),
        .disarm     (finish && (h_kind_q == K_STORE) && (h_atomic_q || resv_hit)),
        .arm_addr   (h_addr_q),
        .probe_addr (probe_addr),
        .hit        (resv_hit)
    );

    mreq_extract #(.DATA_W(DATA_W), .SIZE_W(SIZE_W)) extract_i (
        .raw    (resp_data),
        .nbytes (h_size_q),
        .value  (trimmed)
    );

    // Completion value: trimmed data for reads, success flag for stores.
    always_comb begin
        if (h_kind_q == K_STORE) result = h_atomic_q ? DATA_W'(1) : '0;
        else                     result = trimmed;
    end

    // Access state machine: idle, issue, wait for retry, wait for response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:       if (take && !reject && !sc_fail) state_q <= ST_ISSUE;
                ST_ISSUE:      state_q <= sent ? ST_WAIT_RESP : ST_WAIT_RETRY;
                ST_WAIT_RETRY: if (sent) state_q <= ST_WAIT_RESP;
                ST_WAIT_RESP:  if (finish) state_q <= ST_IDLE;
                default:       state_q <= ST_IDLE;
            endcase
        end
    end

    // Hold the taken request so a refused access can be replayed unchanged.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_kind_q   <= K_FETCH;
            h_atomic_q <= 1'b0;
            h_addr_q   <= '0;
            h_size_q   <= '0;
            h_wdata_q  <= '0;
        end else if (take && !reject && !sc_fail) begin
            h_kind_q   <= in_kind;
            h_atomic_q <= req_atomic && (in_kind != K_FETCH);
            h_addr_q   <= req_addr;
            h_size_q   <= in_size;
            h_wdata_q  <= req_wdata;
        end
    end

    // Blocked flag: raised by a refusal, dropped by an acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n)       blocked_q <= 1'b0;
        else if (refused) blocked_q <= 1'b1;
        else if (sent)    blocked_q <= 1'b0;
    end

    // Completion strobe, result, error flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q      <= 1'b0;
            done_err_q  <= 1'b0;
            done_data_q <= '0;
            retry_err_q <= 1'b0;
        end else begin
            done_q      <= local_done || finish;
            done_err_q  <= take && reject;
            done_data_q <= finish ? result : '0;
            retry_err_q <= port_retry && (state_q != ST_WAIT_RETRY);
        end
    end

    assign req_ready  = (state_q == ST_IDLE);
    assign port_write = (h_kind_q == K_STORE);
    assign port_addr  = h_addr_q;
    assign port_size  = h_size_q;
    assign port_wdata = h_wdata_q;
    assign blocked    = blocked_q;
    assign done       = done_q;
    assign done_data  = done_data_q;
    assign done_err   = done_err_q;
    assign retry_err  = retry_err_q;
endmodule

// File: rtl/mreq_issuer_chk.sv
// Protocol checker for mreq_issuer, attached by bind.
// Assumes: reset is synchronous and active low.
module mreq_issuer_chk #(
    parameter int ADDR_W = 32,
    parameter int SIZE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              port_valid,
    input logic [ADDR_W-1:0] port_addr,
    input logic [SIZE_W-1:0] port_size,
    input logic              port_accept,
    input logic              port_retry,
    input logic              blocked,
    input logic              done,
    input logic              done_err,
    input logic              retry_err
);
    a_r2_refusal_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        port_valid && !port_accept |=> blocked);

    a_r2_held_request_stable: assert property (@(posedge clk) disable iff (!rst_n)
        port_valid && !port_accept |=> $stable(port_addr) && $stable(port_size));

    a_r2_quiet_while_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        blocked && !port_retry |-> !port_valid);

    a_r3_accept_unblocks: assert property (@(posedge clk) disable iff (!rst_n)
        port_valid && port_accept |=> !blocked);

    a_r4_no_take_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
        port_valid || blocked |-> !req_ready);

    a_r5_stray_retry_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        port_retry && !blocked |=> retry_err);

    a_r8_error_is_completion: assert property (@(posedge clk) disable iff (!rst_n)
        done_err |-> done);
endmodule

bind mreq_issuer mreq_issuer_chk #(.ADDR_W(ADDR_W), .SIZE_W(SIZE_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_ready   (req_ready),
    .port_valid  (port_valid),
    .port_addr   (port_addr),
    .port_size   (port_size),
    .port_accept (port_accept),
    .port_retry  (port_retry),
    .blocked     (blocked),
    .done        (done),
    .done_err    (done_err),
    .retry_err   (retry_err)
);

// File: tb/mreq_issuer_tb_top.sv
// Bench for mreq_issuer: a behavioural reference model updated at each
// rising edge and compared with the outputs at each falling edge, plus
// directed end-of-access checks with hand-computed values.
module mreq_issuer_tb_top;
    localparam int AW = 32;
    localparam int DW = 64;
    localparam int SW = 4;
    localparam int S_IDLE = 0, S_ISSUE = 1, S_RETRY = 2, S_RESP = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [1:0]    req_kind = 2'b00;
    logic          req_atomic = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [SW-1:0] req_size = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready;
    logic          port_valid, port_write;
    logic [AW-1:0] port_addr;
    logic [SW-1:0] port_size;
    logic [DW-1:0] port_wdata;
    logic          port_accept = 1'b0;
    logic          port_retry = 1'b0;
    logic          resp_valid = 1'b0;
    logic [DW-1:0] resp_data = '0;
    logic          blocked, done, done_err, retry_err;
    logic [DW-1:0] done_data;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    mreq_issuer dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_atomic(req_atomic),
        .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
        .req_ready(req_ready),
        .port_valid(port_valid), .port_write(port_write), .port_addr(port_addr),
        .port_size(port_size), .port_wdata(port_wdata),
        .port_accept(port_accept), .port_retry(port_retry),
        .resp_valid(resp_valid), .resp_data(resp_data),
        .blocked(blocked), .done(done), .done_data(done_data),
        .done_err(done_err), .retry_err(retry_err)
    );

    // Reference model state.
    int            m_st;
    int            m_kind;
    bit            m_at;
    logic [AW-1:0] m_addr;
    int            m_sz;
    bit            m_rv;
    logic [AW-1:0] m_ra;
    bit            m_done, m_err, m_rerr;
    logic [DW-1:0] m_data;

    // Observations gathered for directed checks.
    logic [DW-1:0] last_data;
    bit            last_err;
    int            pv_count;
    int            rerr_count;
    int            odd_addr_count;

    function automatic logic [DW-1:0] trim(input logic [DW-1:0] v, input int nb);
        if (nb >= 8) return v;
        return v & ((64'd1 << (nb * 8)) - 64'd1);
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Model update on each rising edge from the inputs seen there.
    always @(posedge clk) begin
        int nb;
        cycles++;
        if (!rst_n) begin
            m_st = S_IDLE; m_rv = 0; m_done = 0; m_err = 0; m_rerr = 0; m_data = '0;
            m_kind = 0; m_at = 0; m_addr = '0; m_sz = 0; m_ra = '0;
        end else begin
            m_rerr = port_retry && (m_st != S_RETRY);
            m_done = 0; m_err = 0; m_data = '0;
            case (m_st)
                S_IDLE: if (req_valid) begin
                    nb = (req_kind == 2'b00) ? 4 : int'(req_size);
                    if (req_kind == 2'b11 || !(nb == 1 || nb == 2 || nb == 4 || nb == 8)) begin
                        m_done = 1; m_err = 1;
                    end else if (req_kind == 2'b10 && req_atomic && !(m_rv && m_ra == req_addr)) begin
                        m_done = 1;
                    end else begin
                        m_kind = int'(req_kind); m_at = req_atomic && req_kind != 2'b00;
                        m_addr = req_addr; m_sz = nb; m_st = S_ISSUE;
                    end
                end
                S_ISSUE: m_st = port_accept ? S_RESP : S_RETRY;
                S_RETRY: if (port_retry && port_accept) m_st = S_RESP;
                default: if (resp_valid) begin
                    m_done = 1; m_st = S_IDLE;
                    if (m_kind == 2) begin
                        m_data = m_at ? 64'd1 : 64'd0;
                        if (m_at || (m_rv && m_ra == m_addr)) m_rv = 0;
                    end else begin
                        m_data = trim(resp_data, m_sz);
                        if (m_kind == 1 && m_at) begin m_rv = 1; m_ra = m_addr; end
                    end
                end
            endcase
        end
    end

    // Cycle comparison at the falling edge.
    always @(negedge clk) begin
        bit exp_pv;
        if (rst_n) begin
            exp_pv = (m_st == S_ISSUE) || (m_st == S_RETRY && port_retry);
            chk(req_ready === (m_st == S_IDLE), "R4 req_ready", 64'(req_ready), 64'(m_st == S_IDLE));
            chk(port_valid === exp_pv, (m_st == S_RETRY) ? "R3 port_valid" : "R1 port_valid",
                64'(port_valid), 64'(exp_pv));
            if (exp_pv) begin
                chk(port_addr === m_addr, "R1 port_addr", 64'(port_addr), 64'(m_addr));
                chk(port_size === SW'(m_sz), "R1 port_size", 64'(port_size), 64'(m_sz));
                chk(port_write === (m_kind == 2), "R1 port_write", 64'(port_write), 64'(m_kind == 2));
            end
            chk(blocked === (m_st == S_RETRY), "R2 blocked", 64'(blocked), 64'(m_st == S_RETRY));
            chk(done === m_done, "R6 done", 64'(done), 64'(m_done));
            chk(done_err === m_err, "R8 done_err", 64'(done_err), 64'(m_err));
            chk(retry_err === m_rerr, "R5 retry_err", 64'(retry_err), 64'(m_rerr));
            if (m_done) chk(done_data === m_data, "R7 done_data", done_data, m_data);
            if (done) begin last_data = done_data; last_err = done_err; end
            if (port_valid) pv_count++;
            if (port_valid && port_addr == 32'h0000_0BAD) odd_addr_count++;
            if (retry_err) rerr_count++;
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // One access: request, optional refusals replayed by retry, then response.
    task automatic access(input logic [1:0] k, input bit at, input logic [AW-1:0] a,
                          input logic [SW-1:0] sz, input int refusals,
                          input logic [DW-1:0] rd, input bit is_local);
        pv_count = 0;
        last_data = '1;
        last_err = 0;
        req_valid = 1; req_kind = k; req_atomic = at; req_addr = a; req_size = sz;
        req_wdata = {32'hCAFE_0000, a};
        tick();
        req_valid = 0;
        if (is_local) begin
            tick();
            return;
        end
        port_accept = (refusals == 0);
        tick();
        port_accept = 0;
        for (int r = 0; r < refusals; r++) begin
            tick();
            port_retry = 1; port_accept = (r == refusals - 1);
            tick();
            port_retry = 0; port_accept = 0;
        end
        tick();
        resp_valid = 1; resp_data = rd;
        tick();
        resp_valid = 0;
        tick();
    endtask

    localparam logic [DW-1:0] PAT = 64'h1122_3344_5566_7788;

    initial begin
        repeat (3) tick();
        rst_n = 1;
        tick();
        chk(req_ready === 1'b1 && !port_valid && !blocked && !done, "R4 reset state",
            64'({req_ready, port_valid, blocked, done}), 64'h8);

        access(2'b01, 0, 32'h100, 4'd4, 0, PAT, 0);
        chk(last_data == 64'h5566_7788, "R7 load 4 bytes", last_data, 64'h5566_7788);
        access(2'b01, 0, 32'h104, 4'd1, 0, PAT, 0);
        chk(last_data == 64'h88, "R7 load 1 byte", last_data, 64'h88);
        access(2'b01, 0, 32'h108, 4'd2, 0, PAT, 0);
        chk(last_data == 64'h7788, "R7 load 2 bytes", last_data, 64'h7788);
        access(2'b01, 0, 32'h110, 4'd8, 0, PAT, 0);
        chk(last_data == PAT, "R7 load 8 bytes", last_data, PAT);

        access(2'b00, 0, 32'h200, 4'd0, 2, PAT, 0);
        chk(pv_count == 3, "R3 fetch presented three times", 64'(pv_count), 64'd3);
        chk(last_data == 64'h5566_7788, "R7 fetch fixed width", last_data, 64'h5566_7788);

        access(2'b10, 0, 32'h300, 4'd8, 1, PAT, 0);
        chk(last_data == 64'd0, "R7 plain store result", last_data, 64'd0);

        access(2'b01, 1, 32'h400, 4'd4, 0, PAT, 0);
        access(2'b10, 1, 32'h400, 4'd4, 0, 64'd0, 0);
        chk(last_data == 64'd1 && pv_count == 1, "R11 matching store-conditional", last_data, 64'd1);
        access(2'b10, 1, 32'h400, 4'd4, 0, 64'd0, 1);
        chk(last_data == 64'd0 && pv_count == 0, "R10 reservation spent", last_data, 64'd0);

        access(2'b01, 1, 32'h500, 4'd4, 0, PAT, 0);
        access(2'b10, 1, 32'h504, 4'd4, 0, 64'd0, 1);
        chk(pv_count == 0 && last_data == 64'd0, "R10 other address fails locally", 64'(pv_count), 64'd0);
        access(2'b10, 1, 32'h500, 4'd4, 0, 64'd0, 0);
        chk(last_data == 64'd1, "R9 reservation still armed", last_data, 64'd1);

        access(2'b01, 1, 32'h600, 4'd8, 0, PAT, 0);
        access(2'b10, 0, 32'h600, 4'd8, 0, 64'd0, 0);
        access(2'b10, 1, 32'h600, 4'd8, 0, 64'd0, 1);
        chk(pv_count == 0 && last_data == 64'd0, "R11 plain store disarms", 64'(pv_count), 64'd0);

        access(2'b01, 0, 32'h700, 4'd3, 0, PAT, 1);
        chk(last_err == 1 && pv_count == 0, "R8 size 3 rejected", 64'(last_err), 64'd1);
        access(2'b11, 0, 32'h704, 4'd4, 0, PAT, 1);
        chk(last_err == 1 && pv_count == 0, "R8 kind 11 rejected", 64'(last_err), 64'd1);

        rerr_count = 0;
        port_retry = 1;
        tick();
        port_retry = 0;
        tick();
        chk(rerr_count == 1, "R5 stray retry", 64'(rerr_count), 64'd1);

        last_data = '1;
        resp_valid = 1; resp_data = PAT;
        tick();
        resp_valid = 0;
        tick();
        chk(last_data == '1, "R6 stray response ignored", last_data, '1);

        odd_addr_count = 0;
        pv_count = 0;
        req_valid = 1; req_kind = 2'b01; req_atomic = 0; req_addr = 32'h800; req_size = 4'd2;
        tick();
        req_addr = 32'h0000_0BAD;
        tick();
        tick();
        tick();
        req_valid = 0;
        port_retry = 1; port_accept = 1;
        tick();
        port_retry = 0; port_accept = 0;
        tick();
        resp_valid = 1; resp_data = PAT;
        tick();
        resp_valid = 0;
        tick();
        chk(odd_addr_count == 0, "R4 request ignored while blocked", 64'(odd_addr_count), 64'd0);
        chk(last_data == 64'h7788, "R2 held access completes", last_data, 64'h7788);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    always @(posedge clk) begin
        if (cycles > 20000) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected<=20000 cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule